// File: doc/BRIEF.md
# Two-Digit Combination Lock Sequencer

This block is a Moore state machine that decides whether a two-digit code was keyed in correctly. Each digit is four bits wide. It is taken from the `digit` input only in a cycle where the one-cycle `enter` strobe is high. The expected code is a first digit of 2 followed by a second digit of 3. Both values are named local constants in the top module. The block reports a sticky unlocked status when the code is right and a sticky rejected status when it is wrong. It also drives its three-bit state code on a debug output.

There are two reset inputs: a lock-only reset and a system-wide reset. Either one, or both together, sends the machine back to its idle state, so the user can start a new attempt without disturbing the rest of the chip. The `enter` strobe must already be clean and one cycle long. All outputs are decoded from the state register only.

States and their fixed codes:
- IDLE = 0: waiting for the first digit.
- HAVE_ONE = 1: a correct first digit has been taken.
- MISS_ONE = 2: a wrong first digit has been taken.
- UNLOCKED = 3: the full code was correct.
- REJECTED = 4: the code was wrong.

Transitions:
- IDLE to HAVE_ONE on a strobe with digit 2.
- IDLE to MISS_ONE on a strobe with any other digit.
- HAVE_ONE to UNLOCKED on a strobe with digit 3.
- HAVE_ONE to REJECTED on a strobe with any other digit.
- MISS_ONE to REJECTED on any strobe.
- UNLOCKED and REJECTED are held until a reset.
- Any state goes to IDLE on reset.

Top module: `code_lock`

## Requirements
- R1: After a reset, `state_dbg` is 0 (IDLE) and both `open_o` and `fail_o` are 0.
- R2: The effective reset is the OR of `sys_rst` and `lock_rst`. Both are synchronous and active-high, and either one alone returns the machine to IDLE from any state. A reset wins over an `enter` strobe in the same cycle.
- R3: In a cycle where `enter` is 0, the state does not change, whatever the value on `digit`.
- R4: From IDLE, a strobe with `digit` = 2 moves the state to 1 (HAVE_ONE) on the next clock edge.
- R5: From IDLE, a strobe with any `digit` other than 2 moves the state to 2 (MISS_ONE). `fail_o` stays 0 in that state.
- R6: From MISS_ONE, any strobe moves the state to 4 (REJECTED), whatever the digit.
- R7: From HAVE_ONE, a strobe with `digit` = 3 moves the state to 3 (UNLOCKED).
- R8: From HAVE_ONE, a strobe with any `digit` other than 3 moves the state to 4 (REJECTED).
- R9: UNLOCKED and REJECTED are sticky. Further strobes leave the state unchanged until a reset.
- R10: The outputs follow the Moore rule. `open_o` is 1 exactly in state 3, `fail_o` is 1 exactly in state 4, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| sys_rst | input | 1 | System-wide synchronous reset, active-high |
| lock_rst | input | 1 | Lock-only synchronous reset, active-high |
| enter | input | 1 | One-cycle strobe; `digit` is read while it is high |
| digit | input | 4 | Digit value offered to the lock |
| state_dbg | output | 3 | Current state code, for debugging |
| open_o | output | 1 | High while the lock is unlocked |
| fail_o | output | 1 | High while the entered code is rejected |

## Verification
An `enter` strobe and a reset can arrive in the same cycle. The bench provokes this in two ways:
- It raises `lock_rst` together with a strobe that would unlock the machine from HAVE_ONE.
- It raises `sys_rst` together with a correct first digit from IDLE.

The bench judges each case by requiring the state seen after that edge to be IDLE with both status outputs low. It also raises both resets together from REJECTED. Apart from these cases, the bench sweeps every pair of first and second digits and compares each step against a transition function written from the requirements. Between the two strobes it inserts a cycle with the strobe low and the digit changed.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_HAVE_ONE = 3'd1,
        ST_MISS_ONE = 3'd2,
        ST_UNLOCKED = 3'd3,
        ST_REJECTED = 3'd4
    } lock_state_e;

endpackage

// File: rtl/lock_reset_merge.sv
module lock_reset_merge #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] rst_src,
    output logic             rst_any
);

    assign rst_any = |rst_src;

endmodule

// File: rtl/lock_digit_match.sv
module lock_digit_match #(
    parameter int                        DIGIT_W = 4,
    parameter int                        N_KEYS  = 2,
    parameter logic [N_KEYS*DIGIT_W-1:0] KEYS    = '0
) (
    input  logic [DIGIT_W-1:0] digit,
    output logic [N_KEYS-1:0]  hit
);

    for (genvar k = 0; k < N_KEYS; k++) begin : g_cmp
        assign hit[k] = (digit == KEYS[k*DIGIT_W +: DIGIT_W]);
    end

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enter,
    input  logic               hit_first,
    input  logic               hit_second,
    output logic [STATE_W-1:0] state_code,
    output logic               unlocked,
    output logic               rejected
);

    lock_state_e state_q;
    lock_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transition logic
    always_comb begin
        state_d = state_q;
        if (enter) begin
            unique case (state_q)
                ST_IDLE:     state_d = hit_first  ? ST_HAVE_ONE : ST_MISS_ONE;
                ST_HAVE_ONE: state_d = hit_second ? ST_UNLOCKED : ST_REJECTED;
                ST_MISS_ONE: state_d = ST_REJECTED;
                ST_UNLOCKED: state_d = ST_UNLOCKED;
                ST_REJECTED: state_d = ST_REJECTED;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Moore outputs: decoded from the state register only
    always_comb begin
        state_code = state_q;
        unlocked   = 1'b0;
        rejected   = 1'b0;
        unique case (state_q)
            ST_UNLOCKED: unlocked = 1'b1;
            ST_REJECTED: rejected = 1'b1;
            default: begin
                unlocked = 1'b0;
                rejected = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/code_lock.sv
module code_lock
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               sys_rst,
    input  logic               lock_rst,
    input  logic               enter,
    input  logic [DIGIT_W-1:0] digit,
    output logic [STATE_W-1:0] state_dbg,
    output logic               open_o,
    output logic               fail_o
);

    localparam logic [DIGIT_W-1:0] KEY_FIRST  = DIGIT_W'(2);
    localparam logic [DIGIT_W-1:0] KEY_SECOND = DIGIT_W'(3);
    localparam int                 N_KEYS     = 2;
    localparam logic [N_KEYS*DIGIT_W-1:0] KEY_VEC = {KEY_SECOND, KEY_FIRST};

    logic              rst_any;
    logic [N_KEYS-1:0] hit;

    lock_reset_merge #(.N_SRC(2)) u_rst (
        .rst_src ({lock_rst, sys_rst}),
        .rst_any (rst_any)
    );

    lock_digit_match #(
        .DIGIT_W (DIGIT_W),
        .N_KEYS  (N_KEYS),
        .KEYS    (KEY_VEC)
    ) u_match (
        .digit (digit),
        .hit   (hit)
    );

    lock_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst_any),
        .enter      (enter),
        .hit_first  (hit[0]),
        .hit_second (hit[1]),
        .state_code (state_dbg),
        .unlocked   (open_o),
        .rejected   (fail_o)
    );

endmodule

// File: rtl/code_lock_checker.sv
module code_lock_checker #(
    parameter int DIGIT_W = 4
) (
    input logic               clk,
    input logic               sys_rst,
    input logic               lock_rst,
    input logic               enter,
    input logic [DIGIT_W-1:0] digit,
    input logic [2:0]         state_dbg,
    input logic               open_o,
    input logic               fail_o
);

    logic rst_any;
    assign rst_any = sys_rst || lock_rst;

    p_reset_to_idle_r2: assert property (@(posedge clk)
        rst_any |=> (state_dbg == 3'd0 && !open_o && !fail_o));

    p_hold_no_enter_r3: assert property (@(posedge clk) disable iff (rst_any)
        !enter |=> $stable(state_dbg));

    p_miss_then_reject_r6: assert property (@(posedge clk) disable iff (rst_any)
        (enter && state_dbg == 3'd2) |=> state_dbg == 3'd4);

    p_sticky_end_r9: assert property (@(posedge clk) disable iff (rst_any)
        (state_dbg == 3'd3 || state_dbg == 3'd4) |=> $stable(state_dbg));

    p_open_path_r7: assert property (@(posedge clk) disable iff (rst_any)
        $rose(open_o) |-> ($past(state_dbg) == 3'd1 && $past(enter)
                           && $past(digit) == DIGIT_W'(3)));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst_any)
        !(open_o && fail_o));

    p_open_state_r10: assert property (@(posedge clk) disable iff (rst_any)
        open_o |-> state_dbg == 3'd3);

endmodule

bind code_lock code_lock_checker #(.DIGIT_W(DIGIT_W)) u_chk (.*);

// File: tb/code_lock_tb.sv
module code_lock_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       sys_rst;
    logic       lock_rst;
    logic       enter;
    logic [3:0] digit;
    logic [2:0] state_dbg;
    logic       open_o;
    logic       fail_o;

    int total = 0;
    int bad   = 0;

    code_lock u_dut (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .lock_rst  (lock_rst),
        .enter     (enter),
        .digit     (digit),
        .state_dbg (state_dbg),
        .open_o    (open_o),
        .fail_o    (fail_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // reference transition from the requirements (R4..R9)
    function automatic logic [2:0] model(input logic [2:0] s, input logic [3:0] d);
        case (s)
            3'd0:    return (d == 4'd2) ? 3'd1 : 3'd2;
            3'd1:    return (d == 4'd3) ? 3'd3 : 3'd4;
            3'd2:    return 3'd4;
            default: return s;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] exp);
        logic eo;
        logic ef;
        eo = (exp == 3'd3);
        ef = (exp == 3'd4);
        total++;
        if (state_dbg !== exp || open_o !== eo || fail_o !== ef) begin
            bad++;
            $display("FAIL %s: state=%0d open=%0b fail=%0b expected state=%0d open=%0b fail=%0b (R10 decode)",
                     tag, state_dbg, open_o, fail_o, exp, eo, ef);
        end
    endtask

    task automatic strobe(input logic [3:0] d);
        @(negedge clk);
        enter = 1'b1;
        digit = d;
        @(negedge clk);
        enter = 1'b0;
    endtask

    task automatic do_reset(input bit use_lock);
        @(negedge clk);
        if (use_lock) lock_rst = 1'b1; else sys_rst = 1'b1;
        @(negedge clk);
        lock_rst = 1'b0;
        sys_rst  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] s1;
        logic [2:0] s2;
        sys_rst  = 1'b1;
        lock_rst = 1'b0;
        enter    = 1'b0;
        digit    = 4'd0;
        repeat (3) @(negedge clk);
        sys_rst = 1'b0;
        check("R1 reset state", 3'd0);

        // exhaustive sweep over digit pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                do_reset(((a ^ b) & 1) == 1);
                check("R1 R2 reset returns idle", 3'd0);
                strobe(4'(a));
                s1 = model(3'd0, 4'(a));
                check((a == 2) ? "R4 first digit hit" : "R5 first digit miss", s1);
                // a cycle with the strobe low and the digit changed
                digit = 4'(b) ^ 4'd5;
                @(negedge clk);
                check("R3 no strobe holds state", s1);
                strobe(4'(b));
                s2 = model(s1, 4'(b));
                if (s1 == 3'd2)
                    check("R6 miss then any digit rejects", s2);
                else if (b == 3)
                    check("R7 correct second digit unlocks", s2);
                else
                    check("R8 wrong second digit rejects", s2);
                strobe(4'(a));
                check("R9 end state sticky", s2);
                strobe(4'd3);
                check("R9 end state sticky again", s2);
            end
        end

        // reset collides with an unlocking strobe
        do_reset(1'b0);
        strobe(4'd2);
        check("R4 setup for collision", 3'd1);
        @(negedge clk);
        enter    = 1'b1;
        digit    = 4'd3;
        lock_rst = 1'b1;
        @(negedge clk);
        enter    = 1'b0;
        lock_rst = 1'b0;
        check("R2 lock reset beats strobe", 3'd0);

        @(negedge clk);
        enter   = 1'b1;
        digit   = 4'd2;
        sys_rst = 1'b1;
        @(negedge clk);
        enter   = 1'b0;
        sys_rst = 1'b0;
        check("R2 system reset beats strobe", 3'd0);

        // both resets together from rejected
        strobe(4'd9);
        strobe(4'd9);
        check("R6 reach rejected", 3'd4);
        @(negedge clk);
        sys_rst  = 1'b1;
        lock_rst = 1'b1;
        @(negedge clk);
        sys_rst  = 1'b0;
        lock_rst = 1'b0;
        check("R2 both resets", 3'd0);

        // long idle with wandering digit
        for (int i = 0; i < 16; i++) begin
            digit = 4'(i);
            @(negedge clk);
            check("R3 idle wander", 3'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule